// File: doc/BRIEF.md
# Synthesizer Configuration Serial Port with Deferred Commit

This block receives configuration words for a fractional-N frequency synthesizer over a three-wire, write-only serial link. The link has a serial clock, a serial data line and a load strobe. All three wires are asynchronous to the system clock and are resynchronised inside the block. Each word carries a 20-bit payload and a 4-bit address. The address selects one of four control registers.

The two secondary frequency registers are not applied when they arrive. They hold the fractional numerator, the charge-pump codes, the reference divider and the modulus. Their contents wait in shadow storage until the primary frequency register is written. A valid primary write then moves the primary fields and both shadows to the active outputs on the same clock edge. The same write raises a one-cycle start pulse that launches the downstream calibration and fast-lock sequence. The function register applies as soon as it is written. Frames that carry a prohibited field value are dropped and reported on a one-cycle error output.

Top module: `synth_cfg_serial`

## Requirements
- R1: Bits enter MSB first, one on each rising edge of `ser_clk`. On a rising edge of `ser_load`, the last 24 bits received form the frame: frame[23:4] is the payload D19..D0 and frame[3:0] is the address.
- R2: Each serial input passes through SYNC_STAGES flops (default 2). An edge first sampled at clock edge P is acted on at clock edge P+SYNC_STAGES, and the outputs show the result from that edge onward.
- R3: A valid address-1 frame updates `vco_band` (D16:15), `lo_div` (D14:13) and `n_int` (D11:0).
- R4: An address-2 frame (`cp_norm` D18:16, `cp_fast` D14:12, `n_frac` D11:0) or an address-3 frame (`ref_div` D19:12, `n_mod` D11:0) only loads shadow storage; the last one written wins. The shadows reach the outputs only at the next valid address-1 frame.
- R5: An address-4 frame applies at once, with `cal_time` D19:16, `lock_cnt_sel` D14, `lock_mode` D13, `lo_mute` D12, `fast_en` D11, `fast_timer` D10:7, `cp_tristate` D6, `dsm_en` D5, `mix_en` D4, `lo_mode` D3:2 and `lo_level` D1:0. It leaves the frequency outputs unchanged.
- R6: A valid address-1 frame pulses `lock_start` high for exactly one cycle, on the same edge as the commit, if `pwr_down` is low at that edge. If `pwr_down` is high, the values are still committed but no pulse is given.
- R7: An address-1 frame with D16:15 = 3 changes no output and gives no start pulse. It pulses `cfg_err` for one cycle.
- R8: An address-4 frame with D19:16 equal to 0 or greater than 11 changes no output and pulses `cfg_err` for one cycle.
- R9: Frames to addresses 0 and 5 to 15 change no output or shadow and raise no error.
- R10: After reset, every output is zero.
- R11: A frame longer than 24 bits is decoded from its last 24 bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Frame load strobe; decoded on its rising edge |
| pwr_down | input | 1 | High blocks the start pulse |
| vco_band | output | 2 | Oscillator band select |
| lo_div | output | 2 | Output divider code (1, 2, 4, 8) |
| n_int | output | 12 | Integer divide value |
| cp_norm | output | 3 | Normal charge-pump current code |
| cp_fast | output | 3 | Fast-lock charge-pump current code |
| n_frac | output | 12 | Fractional numerator |
| ref_div | output | 8 | Reference divider |
| n_mod | output | 12 | Fractional modulus |
| cal_time | output | 4 | Calibration time code |
| lock_cnt_sel | output | 1 | Lock-count select |
| lock_mode | output | 1 | Lock-detect mode |
| lo_mute | output | 1 | Mute local output while unlocked |
| fast_en | output | 1 | Fast-lock enable |
| fast_timer | output | 4 | Fast-lock timer code |
| cp_tristate | output | 1 | Charge-pump tri-state |
| dsm_en | output | 1 | Modulator enable |
| mix_en | output | 1 | Mixer enable |
| lo_mode | output | 2 | Local operating mode |
| lo_level | output | 2 | Local output level |
| lock_start | output | 1 | One-cycle start pulse on commit |
| cfg_err | output | 1 | One-cycle pulse on a prohibited frame |

## Verification
The bench sends the secondary registers first and several times before a primary write. This separates true deferral from immediate application, and it shows that the last write to a shadow wins. Primary writes are made with power-down both low and high, which separates the commit from the start pulse. Prohibited values, unused addresses and over-long frames are mixed with valid frames, so a dropped frame that leaks through shows up as a change to a register written earlier. One frame has its outputs watched in the cycle just before and the cycle just after the predicted action edge, which pins down the synchroniser latency.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
   localparam int DATA_W = 20;

   localparam int ADR_FREQ1 = 1;
   localparam int ADR_FREQ2 = 2;
   localparam int ADR_FREQ3 = 3;
   localparam int ADR_FUNC  = 4;

   localparam int VCO_BAD   = 3;
   localparam int CAL_MAX   = 11;

   typedef struct packed {
      logic [1:0]  vco;
      logic [1:0]  div;
      logic [11:0] nint;
   } freq1_t;

   typedef struct packed {
      logic [2:0]  cp_n;
      logic [2:0]  cp_f;
      logic [11:0] frac;
   } freq2_t;

   typedef struct packed {
      logic [7:0]  rdiv;
      logic [11:0] modv;
   } freq3_t;

   typedef struct packed {
      logic [3:0] cal;
      logic       lcs;
      logic       ldm;
      logic       mute;
      logic       fen;
      logic [3:0] ftm;
      logic       tri_st;
      logic       dsm;
      logic       mix;
      logic [1:0] mode;
      logic [1:0] lvl;
   } func_t;

   function automatic freq1_t unpack_f1(input logic [DATA_W-1:0] d);
      freq1_t r;
      r.vco  = d[16:15];
      r.div  = d[14:13];
      r.nint = d[11:0];
      return r;
   endfunction

   function automatic freq2_t unpack_f2(input logic [DATA_W-1:0] d);
      freq2_t r;
      r.cp_n = d[18:16];
      r.cp_f = d[14:12];
      r.frac = d[11:0];
      return r;
   endfunction

   function automatic freq3_t unpack_f3(input logic [DATA_W-1:0] d);
      freq3_t r;
      r.rdiv = d[19:12];
      r.modv = d[11:0];
      return r;
   endfunction

   function automatic func_t unpack_fn(input logic [DATA_W-1:0] d);
      func_t r;
      r.cal    = d[19:16];
      r.lcs    = d[14];
      r.ldm    = d[13];
      r.mute   = d[12];
      r.fen    = d[11];
      r.ftm    = d[10:7];
      r.tri_st = d[6];
      r.dsm    = d[5];
      r.mix    = d[4];
      r.mode   = d[3:2];
      r.lvl    = d[1:0];
      return r;
   endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_chk_stages
      $error("scfg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_chk_width
      $error("scfg_sync: W must be at least 1");
   end

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sdat_s,
   input  logic               load_s,
   output logic [FRAME_W-1:0] word,
   output logic               word_vld
);
   if (FRAME_W < 2) begin : g_chk_frame
      $error("scfg_shifter: FRAME_W too small");
   end

   logic               sclk_d;
   logic               load_d;
   logic [FRAME_W-1:0] sh;
   logic               bit_en;

   assign bit_en = sclk_s & ~sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         load_d <= 1'b0;
         sh     <= '0;
      end else begin
         sclk_d <= sclk_s;
         load_d <= load_s;
         if (bit_en) sh <= {sh[FRAME_W-2:0], sdat_s};
      end
   end

   assign word     = sh;
   assign word_vld = load_s & ~load_d;

   // R1: a new bit lands in the LSB after a serial clock rise
   assert_bit_enters_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_s && !sclk_d) |=> (sh[0] == $past(sdat_s)));

   // R1: a frame strobe cannot fire on two cycles in a row
   assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);
endmodule

// File: rtl/scfg_regfile.sv
module scfg_regfile
   import scfg_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int FRAME_W = DATA_W + ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] word,
   input  logic               word_vld,
   input  logic               pwr_down,
   output freq1_t             f1,
   output freq2_t             f2,
   output freq3_t             f3,
   output func_t              fn,
   output logic               start,
   output logic               err
);
   if (ADDR_W < 3) begin : g_chk_addr
      $error("scfg_regfile: ADDR_W must reach address 4");
   end
   if (FRAME_W != DATA_W + ADDR_W) begin : g_chk_frame
      $error("scfg_regfile: FRAME_W must equal DATA_W + ADDR_W");
   end

   logic [DATA_W-1:0] pay;
   logic [ADDR_W-1:0] adr;
   freq1_t            new1;
   func_t             newf;
   freq2_t            sh2;
   freq3_t            sh3;
   logic              hit1, hit2, hit3, hit4;
   logic              bad1, bad4;
   logic              commit, apply4;

   assign pay = word[FRAME_W-1 -: DATA_W];
   assign adr = word[ADDR_W-1:0];

   assign new1 = unpack_f1(pay);
   assign newf = unpack_fn(pay);

   assign hit1 = word_vld && (adr == ADDR_W'(ADR_FREQ1));
   assign hit2 = word_vld && (adr == ADDR_W'(ADR_FREQ2));
   assign hit3 = word_vld && (adr == ADDR_W'(ADR_FREQ3));
   assign hit4 = word_vld && (adr == ADDR_W'(ADR_FUNC));

   assign bad1   = hit1 && (new1.vco == 2'(VCO_BAD));
   assign bad4   = hit4 && ((newf.cal == 4'd0) || (newf.cal > 4'(CAL_MAX)));
   assign commit = hit1 && !bad1;
   assign apply4 = hit4 && !bad4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh2 <= '0;
         sh3 <= '0;
      end else begin
         if (hit2) sh2 <= unpack_f2(pay);
         if (hit3) sh3 <= unpack_f3(pay);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1 <= '0;
         f2 <= '0;
         f3 <= '0;
      end else if (commit) begin
         f1 <= new1;
         f2 <= sh2;
         f3 <= sh3;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fn <= '0;
      else if (apply4) fn <= newf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start <= 1'b0;
         err   <= 1'b0;
      end else begin
         start <= commit && !pwr_down;
         err   <= bad1 || bad4;
      end
   end

   // R4: active secondary registers move only on a commit
   assert_hold_secondary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(f2) && $stable(f3)));

   // R6: start pulse lasts exactly one cycle
   assert_start_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   // R6: start pulse only when power-down was low at the commit edge
   assert_start_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !$past(pwr_down));

   // R7: the prohibited oscillator band never reaches the outputs
   assert_no_bad_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
      f1.vco != 2'(VCO_BAD));

   // R8: calibration code never exceeds its limit
   assert_cal_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fn.cal <= 4'(CAL_MAX));

   // R7: an error pulse is a single cycle
   assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

// File: rtl/synth_cfg_serial.sv
module synth_cfg_serial
   import scfg_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_clk,
   input  logic        ser_dat,
   input  logic        ser_load,
   input  logic        pwr_down,
   output logic [1:0]  vco_band,
   output logic [1:0]  lo_div,
   output logic [11:0] n_int,
   output logic [2:0]  cp_norm,
   output logic [2:0]  cp_fast,
   output logic [11:0] n_frac,
   output logic [7:0]  ref_div,
   output logic [11:0] n_mod,
   output logic [3:0]  cal_time,
   output logic        lock_cnt_sel,
   output logic        lock_mode,
   output logic        lo_mute,
   output logic        fast_en,
   output logic [3:0]  fast_timer,
   output logic        cp_tristate,
   output logic        dsm_en,
   output logic        mix_en,
   output logic [1:0]  lo_mode,
   output logic [1:0]  lo_level,
   output logic        lock_start,
   output logic        cfg_err
);
   localparam int FRAME_W = DATA_W + ADDR_W;

   logic [2:0]         raw_in;
   logic [2:0]         syn;
   logic [FRAME_W-1:0] word;
   logic               word_vld;
   freq1_t             f1;
   freq2_t             f2;
   freq3_t             f3;
   func_t              fn;

   assign raw_in = {ser_clk, ser_dat, ser_load};

   scfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   scfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (syn[2]),
      .sdat_s   (syn[1]),
      .load_s   (syn[0]),
      .word     (word),
      .word_vld (word_vld)
   );

   scfg_regfile #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .word     (word),
      .word_vld (word_vld),
      .pwr_down (pwr_down),
      .f1       (f1),
      .f2       (f2),
      .f3       (f3),
      .fn       (fn),
      .start    (lock_start),
      .err      (cfg_err)
   );

   assign vco_band     = f1.vco;
   assign lo_div       = f1.div;
   assign n_int        = f1.nint;
   assign cp_norm      = f2.cp_n;
   assign cp_fast      = f2.cp_f;
   assign n_frac       = f2.frac;
   assign ref_div      = f3.rdiv;
   assign n_mod        = f3.modv;
   assign cal_time     = fn.cal;
   assign lock_cnt_sel = fn.lcs;
   assign lock_mode    = fn.ldm;
   assign lo_mute      = fn.mute;
   assign fast_en      = fn.fen;
   assign fast_timer   = fn.ftm;
   assign cp_tristate  = fn.tri_st;
   assign dsm_en       = fn.dsm;
   assign mix_en       = fn.mix;
   assign lo_mode      = fn.mode;
   assign lo_level     = fn.lvl;

   // R3: a start pulse always comes with a legal oscillator band
   assert_start_legal_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_start |-> (vco_band != 2'd3));
endmodule

// File: tb/synth_cfg_serial_test.sv
`timescale 1ns/1ps
module synth_cfg_serial_test;
   localparam int N  = 2;
   localparam int FW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0, pwr_down = 1'b0;
   logic [1:0]  vco_band, lo_div, lo_mode, lo_level;
   logic [11:0] n_int, n_frac, n_mod;
   logic [2:0]  cp_norm, cp_fast;
   logic [7:0]  ref_div;
   logic [3:0]  cal_time, fast_timer;
   logic        lock_cnt_sel, lock_mode, lo_mute, fast_en, cp_tristate, dsm_en, mix_en;
   logic        lock_start, cfg_err;

   always #2.5 clk = ~clk;

   synth_cfg_serial #(.ADDR_W(4), .SYNC_STAGES(N)) uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_load(ser_load), .pwr_down(pwr_down),
      .vco_band(vco_band), .lo_div(lo_div), .n_int(n_int),
      .cp_norm(cp_norm), .cp_fast(cp_fast), .n_frac(n_frac),
      .ref_div(ref_div), .n_mod(n_mod), .cal_time(cal_time),
      .lock_cnt_sel(lock_cnt_sel), .lock_mode(lock_mode), .lo_mute(lo_mute),
      .fast_en(fast_en), .fast_timer(fast_timer), .cp_tristate(cp_tristate),
      .dsm_en(dsm_en), .mix_en(mix_en), .lo_mode(lo_mode), .lo_level(lo_level),
      .lock_start(lock_start), .cfg_err(cfg_err)
   );

   int    total = 0;
   int    bad   = 0;
   string phase = "R10";
   bit    done  = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model: behavioural, delayed view of the raw pins
   logic [2:0]  hist[$];
   logic        bq[$];
   logic [19:0] m1, m2, m3, m4, s2, s3;
   logic        m_start, m_err;

   task automatic model_clear();
      hist.delete();
      for (int i = 0; i < N + 2; i++) hist.push_back(3'b000);
      bq.delete();
      for (int i = 0; i < FW; i++) bq.push_back(1'b0);
      m1 = '0; m2 = '0; m3 = '0; m4 = '0; s2 = '0; s3 = '0;
      m_start = 0; m_err = 0;
   endtask

   initial model_clear();

   always @(posedge clk) begin
      if (!rst_n) model_clear();
      else begin
         logic [2:0]  cur, old;
         logic [23:0] w;
         logic [19:0] d;
         logic [3:0]  a;
         hist.push_back({ser_clk, ser_dat, ser_load});
         if (hist.size() > N + 2) void'(hist.pop_front());
         cur = hist[hist.size() - 1 - N];
         old = hist[hist.size() - 2 - N];
         for (int i = 0; i < FW; i++) w[FW-1-i] = bq[i];
         m_start = 0; m_err = 0;
         if (cur[2] && !old[2]) begin
            bq.push_back(cur[1]);
            void'(bq.pop_front());
         end
         if (cur[0] && !old[0]) begin
            d = w[23:4]; a = w[3:0];
            case (a)
               4'd1: if (d[16:15] == 2'd3) m_err = 1;
                     else begin
                        m1 = d; m2 = s2; m3 = s3;
                        m_start = !pwr_down;
                     end
               4'd2: s2 = d;
               4'd3: s3 = d;
               4'd4: if (d[19:16] == 0 || d[19:16] > 11) m_err = 1;
                     else m4 = d;
               default: ;
            endcase
         end
      end
   end

   int n_start = 0, n_err = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({phase, " R3 freq1"}, {16'd0, vco_band, lo_div, n_int},
               {16'd0, m1[16:15], m1[14:13], m1[11:0]});
         check({phase, " R4 freq2"}, {14'd0, cp_norm, cp_fast, n_frac},
               {14'd0, m2[18:16], m2[14:12], m2[11:0]});
         check({phase, " R4 freq3"}, {12'd0, ref_div, n_mod}, {12'd0, m3});
         check({phase, " R5 func"},
               {13'd0, cal_time, lock_cnt_sel, lock_mode, lo_mute, fast_en, fast_timer,
                cp_tristate, dsm_en, mix_en, lo_mode, lo_level},
               {13'd0, m4[19:16], m4[14:0]});
         check({phase, " R6 start"}, {31'd0, lock_start}, {31'd0, m_start});
         check({phase, " R7 err"}, {31'd0, cfg_err}, {31'd0, m_err});
         if (lock_start) n_start++;
         if (cfg_err)    n_err++;
      end
   end

   function automatic logic [19:0] mk1(input logic [1:0] v, input logic [1:0] dv, input logic [11:0] ni);
      return {3'b000, v, dv, 1'b0, ni};
   endfunction
   function automatic logic [19:0] mk2(input logic [2:0] c1, input logic [2:0] c2, input logic [11:0] fr);
      return {1'b0, c1, 1'b0, c2, fr};
   endfunction
   function automatic logic [19:0] mk4(input logic [3:0] cal, input logic [14:0] rest);
      return {cal, 1'b0, rest};
   endfunction

   task automatic shift_bits(input logic [31:0] bits, input int nb);
      for (int i = nb - 1; i >= 0; i--) begin
         @(negedge clk); ser_dat = bits[i]; ser_clk = 1'b0;
         repeat (3) @(negedge clk);
         ser_clk = 1'b1;
         repeat (3) @(negedge clk);
         ser_clk = 1'b0;
      end
   endtask

   task automatic pulse_load();
      @(negedge clk); ser_load = 1'b1;
      repeat (3) @(negedge clk);
      ser_load = 1'b0;
      repeat (N + 4) @(negedge clk);
   endtask

   task automatic send(input logic [3:0] a, input logic [19:0] d);
      shift_bits({8'd0, d, a}, FW);
      pulse_load();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: reset values
      check("R10 reset freq", {vco_band, lo_div, n_int, n_frac, n_mod}, 0);
      check("R10 reset misc", {ref_div, cal_time, lock_start, cfg_err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      phase = "R5";
      send(4'd4, mk4(4'd5, 15'h5A5C));
      check("R5 cal applied", cal_time, 4'd5);
      check("R5 freq untouched", n_int, 0);

      phase = "R4";
      send(4'd2, mk2(3'd3, 3'd6, 12'h111));
      send(4'd3, {8'h21, 12'hC00});
      send(4'd2, mk2(3'd5, 3'd2, 12'h0A5));
      check("R4 shadow not visible", {n_frac, n_mod}, 0);

      phase = "R3";
      n_start = 0;
      send(4'd1, mk1(2'd1, 2'd2, 12'd128));
      check("R3 n_int", n_int, 12'd128);
      check("R4 last shadow committed", n_frac, 12'h0A5);
      check("R4 modulus committed", n_mod, 12'hC00);
      check("R6 one start pulse", n_start, 1);

      phase = "R6";
      n_start = 0;
      pwr_down = 1'b1;
      send(4'd2, mk2(3'd7, 3'd1, 12'd25));
      send(4'd1, mk1(2'd2, 2'd3, 12'd4091));
      check("R6 committed in power-down", n_frac, 12'd25);
      check("R6 no pulse in power-down", n_start, 0);
      pwr_down = 1'b0;

      phase = "R7";
      n_err = 0; n_start = 0;
      send(4'd1, mk1(2'd3, 2'd0, 12'd40));
      check("R7 band kept", {vco_band, n_int}, {2'd2, 12'd4091});
      check("R7 err pulse", n_err, 1);
      check("R7 no start", n_start, 0);

      phase = "R8";
      n_err = 0;
      send(4'd4, mk4(4'd0, 15'h7FFF));
      send(4'd4, mk4(4'd12, 15'h0001));
      check("R8 func kept", cal_time, 4'd5);
      check("R8 two err pulses", n_err, 2);
      send(4'd4, mk4(4'd11, 15'h1234));
      check("R8 limit accepted", cal_time, 4'd11);

      phase = "R9";
      n_err = 0;
      send(4'd0, 20'hFFFFF);
      send(4'd5, 20'hFFFFF);
      send(4'd15, 20'hFFFFF);
      send(4'd1, mk1(2'd0, 2'd1, 12'd35));
      check("R9 shadow untouched", {ref_div, n_frac}, {8'h21, 12'd25});
      check("R9 no err", n_err, 0);

      phase = "R11";
      shift_bits(32'h0000_00FF, 8);
      shift_bits({8'd0, mk1(2'd1, 2'd0, 12'hABC), 4'd1}, FW);
      pulse_load();
      check("R11 long frame", n_int, 12'hABC);

      phase = "R2";
      shift_bits({8'd0, mk4(4'd3, 15'h0F0F), 4'd4}, FW);
      @(negedge clk); ser_load = 1'b1;
      @(posedge clk);
      repeat (N - 1) @(posedge clk);
      @(negedge clk);
      check("R2 before action edge", cal_time, 4'd11);
      @(posedge clk);
      @(negedge clk);
      check("R2 at action edge", cal_time, 4'd3);
      ser_load = 1'b0;
      repeat (N + 4) @(negedge clk);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule